// File: doc/BRIEF.md
# Serial SAR Converter Control Logic

This block is the digital side of a four-input successive-approximation converter with a synchronous serial port. Everything runs from the serial clock `dclk`. Input bits are taken on its rising edge, and output bits change on its falling edge.

While chip select is low, the block waits for a start bit on the data input. It then shifts in the rest of an eight-bit command. The command gives the input multiplexer pair, the resolution request and the power policy. An acquisition window opens in the last three clocks of the command. Once the command is complete, the block runs a bit-by-bit approximation on a trial code bus. An external comparator answers each trial on a one-bit input. The result leaves the block most significant bit first.

The next command may arrive while the current result is still being shifted out. The receiver starts listening again exactly four clocks before the conversion ends. This lets a new conversion begin every 15 clocks at full resolution, or every 11 clocks at reduced resolution.

Top module: `sar_adc_ctrl`

## Requirements
- R1: While chip select is low, the block ignores data-input zeros until it samples a 1 on a rising `dclk` edge. That bit is the start bit (bit 7). The next seven rising edges deliver bits 6..0 in order: A2, A1, A0, resolution bit, single/differential bit, PD1, PD0.
- R2: `muxPos` updates on the edge that delivers A0, and takes the value {A1,A2}. `muxNeg` updates on the edge that delivers the single/differential bit. It becomes 3'b100 (the common pin) when that bit is 1, and {1'b0, muxPos^1} (the paired input) when that bit is 0.
- R3: `acquire` is high for exactly the three clock periods that follow the rising edges carrying the resolution bit, the single/differential bit and PD1. It is low at all other times.
- R4: `busy` rises on the falling edge after the edge that completes the command, and it stays high for one clock only.
- R5: The result bits appear on `dout` one per clock, most significant bit first, each changing on a falling edge. The first bit follows the clock after `busy` rises. The result is the straight-binary floor code of the held input, judged through `comp`, which is 1 when the input is at or above `dacCode`. The clock after the last bit drives `dout` to 0.
- R6: If `modePin` is low, every conversion has full resolution (12 bits). If `modePin` is high, a resolution bit of 1 gives an 8-bit conversion, which ends four clocks earlier and trials only the upper 8 bits of `dacCode`.
- R7: After a command completes, DIN is ignored for RES_BITS-5 rising edges (or LOW_BITS-5 edges in 8-bit mode). A start bit can therefore be accepted 15 clocks after the previous one at full resolution, or 11 clocks after at reduced resolution, while the previous result is still being shifted out.
- R8: PD code 00 keeps `powered` high only during acquisition and conversion. Code 11, and the unused codes 01 and 10, keep it high at all times.
- R9: `shdnN` low forces `powered` low at once.
- R10: `outEn` is low while chip select is high. A rising edge with chip select high aborts any command or conversion in progress, and the block then waits for a new start bit.
- R11: After reset, `dout`, `busy`, `acquire`, `powered` and `dacCode` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dclk | input | 1 | Serial and conversion clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select, active low |
| din | input | 1 | Serial command input |
| modePin | input | 1 | Allows the resolution bit to select 8-bit conversion |
| shdnN | input | 1 | Shutdown, active low |
| comp | input | 1 | Comparator answer: input at or above trial code |
| dout | output | 1 | Serial result output |
| busy | output | 1 | Conversion start flag |
| outEn | output | 1 | Drive enable for dout and busy |
| acquire | output | 1 | Sampling switch closed |
| powered | output | 1 | Analog power request |
| dacCode | output | RES_BITS | Trial code for the capacitor DAC |
| muxPos | output | 2 | Positive input channel |
| muxNeg | output | 3 | Negative input: 0-3 a channel, 4 the common pin |

## Verification
During overlap, reception of the next command and shifting out of the previous result fall in the same clocks. The bench provokes this with back-to-back commands at both resolutions. It keeps DIN high through the whole ignore window, so a start bit taken one clock early would shift the second command. The previous result is judged bit by bit from `dout`. The second conversion is judged by when `busy` rises and by its own result, computed from a different held input.

// File: rtl/sar_adc_pkg.sv
`timescale 1ns/1ps
package sar_adc_pkg;

  typedef enum logic [1:0] {
    RX_HUNT  = 2'd0,
    RX_SHIFT = 2'd1,
    RX_HOLD  = 2'd2
  } rxState_e;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic load;       // command complete: seed trial code
    logic step;       // one approximation decision this edge
    logic last;       // final decision of this conversion
    logic startFlag;  // conversion seeded, first decision pending
    logic abort;      // chip select high
  } sarStrobe_t;

endpackage

// File: rtl/sar_adc_seq.sv
`timescale 1ns/1ps
module sar_adc_seq
  import sar_adc_pkg::*;
#(
  parameter int RES_BITS = 12,
  parameter int LOW_BITS = 8
) (
  input  logic       dclk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       din,
  input  logic       modePin,
  input  logic       shdnN,
  output sarStrobe_t strb,
  output logic       acquire,
  output logic       powered,
  output logic [1:0] muxPos,
  output logic [2:0] muxNeg
);

  localparam int CNT_W = $clog2(RES_BITS + 1);
  localparam logic [CNT_W-1:0] HOLD_FULL  = CNT_W'(RES_BITS - 5);
  localparam logic [CNT_W-1:0] HOLD_LOW   = CNT_W'(LOW_BITS - 5);
  localparam logic [CNT_W-1:0] STEPS_FULL = CNT_W'(RES_BITS);
  localparam logic [CNT_W-1:0] STEPS_LOW  = CNT_W'(LOW_BITS);
  localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);

  rxState_e         rxState;
  logic [2:0]       bitCnt;
  logic [2:0]       shiftReg;
  logic [CNT_W-1:0] holdCnt;
  logic [CNT_W-1:0] stepsLeft;
  logic             convActive;
  logic             firstPending;
  logic             pdKeep;
  logic             byteDone;
  logic             pickLow;

  // shiftReg after six shifts: [2]=resolution bit, [1]=sgl/dif, [0]=PD1
  assign byteDone = (rxState == RX_SHIFT) && (bitCnt == 3'd6) && !csN;
  assign pickLow  = modePin & shiftReg[2];

  always_ff @(posedge dclk or negedge rstN) begin
    if (!rstN) begin
      rxState      <= RX_HUNT;
      bitCnt       <= '0;
      shiftReg     <= '0;
      holdCnt      <= '0;
      stepsLeft    <= '0;
      convActive   <= 1'b0;
      firstPending <= 1'b0;
      pdKeep       <= 1'b0;
      muxPos       <= '0;
      muxNeg       <= 3'b100;
    end else if (csN) begin
      rxState      <= RX_HUNT;
      bitCnt       <= '0;
      holdCnt      <= '0;
      stepsLeft    <= '0;
      convActive   <= 1'b0;
      firstPending <= 1'b0;
    end else begin
      case (rxState)
        RX_HUNT: begin
          if (din) begin
            rxState <= RX_SHIFT;
            bitCnt  <= '0;
          end
        end
        RX_SHIFT: begin
          shiftReg <= {shiftReg[1:0], din};
          bitCnt   <= bitCnt + 3'd1;
          if (bitCnt == 3'd2) muxPos <= {shiftReg[0], shiftReg[1]};
          if (bitCnt == 3'd4) muxNeg <= din ? 3'b100 : {1'b0, muxPos ^ 2'b01};
          if (bitCnt == 3'd6) begin
            rxState <= RX_HOLD;
            holdCnt <= pickLow ? HOLD_LOW : HOLD_FULL;
            pdKeep  <= ({shiftReg[0], din} != 2'b00);
          end
        end
        RX_HOLD: begin
          holdCnt <= holdCnt - ONE;
          if (holdCnt <= ONE) begin
            rxState <= RX_HUNT;
            holdCnt <= '0;
          end
        end
        default: rxState <= RX_HUNT;
      endcase

      if (byteDone) begin
        convActive   <= 1'b1;
        firstPending <= 1'b1;
        stepsLeft    <= pickLow ? STEPS_LOW : STEPS_FULL;
      end else if (convActive) begin
        firstPending <= 1'b0;
        stepsLeft    <= stepsLeft - ONE;
        if (stepsLeft == ONE) convActive <= 1'b0;
      end
    end
  end

  always_comb begin
    strb.load      = byteDone;
    strb.step      = convActive && !csN;
    strb.last      = convActive && !csN && (stepsLeft == ONE);
    strb.startFlag = firstPending;
    strb.abort     = csN;
  end

  assign acquire = (rxState == RX_SHIFT) && (bitCnt >= 3'd4);
  assign powered = shdnN & (pdKeep | acquire | convActive);

endmodule

// File: rtl/sar_adc_core.sv
`timescale 1ns/1ps
module sar_adc_core
  import sar_adc_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic                dclk,
  input  logic                rstN,
  input  logic                csN,
  input  logic                comp,
  input  sarStrobe_t          strb,
  output logic [RES_BITS-1:0] dacCode,
  output logic                dout,
  output logic                busy
);

  localparam logic [RES_BITS-1:0] TOP_BIT = {1'b1, {(RES_BITS-1){1'b0}}};

  logic [RES_BITS-1:0] trial;
  logic [RES_BITS-1:0] mask;
  logic [RES_BITS-1:0] trialNext;
  logic                lastBit;
  logic                bitValid;
  logic                doutReg;
  logic                busyReg;

  always_comb begin
    trialNext = comp ? trial : (trial & ~mask);
    if (!strb.last) trialNext = trialNext | (mask >> 1);
  end

  // decisions on the rising edge
  always_ff @(posedge dclk or negedge rstN) begin
    if (!rstN) begin
      trial    <= '0;
      mask     <= '0;
      lastBit  <= 1'b0;
      bitValid <= 1'b0;
    end else if (strb.abort) begin
      trial    <= '0;
      mask     <= '0;
      bitValid <= 1'b0;
    end else if (strb.load) begin
      trial    <= TOP_BIT;
      mask     <= TOP_BIT;
      bitValid <= 1'b0;
    end else if (strb.step) begin
      trial    <= trialNext;
      mask     <= mask >> 1;
      lastBit  <= comp;
      bitValid <= 1'b1;
    end else begin
      bitValid <= 1'b0;
    end
  end

  // serial outputs on the falling edge
  always_ff @(negedge dclk or negedge rstN) begin
    if (!rstN) begin
      doutReg <= 1'b0;
      busyReg <= 1'b0;
    end else if (csN) begin
      doutReg <= 1'b0;
      busyReg <= 1'b0;
    end else begin
      doutReg <= bitValid & lastBit;
      busyReg <= strb.startFlag;
    end
  end

  assign dacCode = trial;
  assign dout    = doutReg;
  assign busy    = busyReg;

endmodule

// File: rtl/sar_adc_ctrl.sv
`timescale 1ns/1ps
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int RES_BITS = 12,
  parameter int LOW_BITS = 8
) (
  input  logic                dclk,
  input  logic                rstN,
  input  logic                csN,
  input  logic                din,
  input  logic                modePin,
  input  logic                shdnN,
  input  logic                comp,
  output logic                dout,
  output logic                busy,
  output logic                outEn,
  output logic                acquire,
  output logic                powered,
  output logic [RES_BITS-1:0] dacCode,
  output logic [1:0]          muxPos,
  output logic [2:0]          muxNeg
);

  sarStrobe_t strb;

  sar_adc_seq #(.RES_BITS(RES_BITS), .LOW_BITS(LOW_BITS)) uSeq (
    .dclk    (dclk),
    .rstN    (rstN),
    .csN     (csN),
    .din     (din),
    .modePin (modePin),
    .shdnN   (shdnN),
    .strb    (strb),
    .acquire (acquire),
    .powered (powered),
    .muxPos  (muxPos),
    .muxNeg  (muxNeg)
  );

  sar_adc_core #(.RES_BITS(RES_BITS)) uCore (
    .dclk    (dclk),
    .rstN    (rstN),
    .csN     (csN),
    .comp    (comp),
    .strb    (strb),
    .dacCode (dacCode),
    .dout    (dout),
    .busy    (busy)
  );

  assign outEn = ~csN;

endmodule

// File: rtl/sar_adc_ctrl_chk.sv
`timescale 1ns/1ps
module sar_adc_ctrl_chk #(
  parameter int RES_BITS = 12
) (
  input logic                dclk,
  input logic                rstN,
  input logic                busy,
  input logic                acquire,
  input logic                powered,
  input logic                shdnN,
  input logic [RES_BITS-1:0] dacCode,
  input logic [1:0]          muxPos
);

  assert_busy_single_R4: assert property (@(posedge dclk) disable iff (!rstN)
    busy |=> !busy);

  assert_trial_seed_R5: assert property (@(posedge dclk) disable iff (!rstN)
    busy |-> ($countones(dacCode) == 1));

  assert_acq_not_busy_R3: assert property (@(posedge dclk) disable iff (!rstN)
    acquire |-> !busy);

  assert_busy_powered_R8: assert property (@(posedge dclk) disable iff (!rstN)
    (busy && shdnN) |-> powered);

  assert_pos_steady_R2: assert property (@(posedge dclk) disable iff (!rstN)
    acquire |-> $stable(muxPos));

endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.RES_BITS(RES_BITS)) uChk (
  .dclk    (dclk),
  .rstN    (rstN),
  .busy    (busy),
  .acquire (acquire),
  .powered (powered),
  .shdnN   (shdnN),
  .dacCode (dacCode),
  .muxPos  (muxPos)
);

// File: tb/sim_sar_adc_ctrl.sv
`timescale 1ns/1ps
module sim_sar_adc_ctrl;

  logic        clk = 1'b0;
  logic        rstN, csN, din, modePin, shdnN;
  logic        dout, busy, outEn, acquire, powered;
  logic [11:0] dacCode;
  logic [1:0]  muxPos;
  logic [2:0]  muxNeg;
  logic [11:0] vinNow;
  logic        comp;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  // ideal comparator against the held input
  assign comp = (vinNow >= dacCode);

  sar_adc_ctrl u0 (
    .dclk(clk), .rstN(rstN), .csN(csN), .din(din), .modePin(modePin),
    .shdnN(shdnN), .comp(comp), .dout(dout), .busy(busy), .outEn(outEn),
    .acquire(acquire), .powered(powered), .dacCode(dacCode),
    .muxPos(muxPos), .muxNeg(muxNeg)
  );

  typedef struct packed {
    logic [7:0]  ctrl;
    logic        pin;
    logic [11:0] vin;
    logic [11:0] code;
    logic [1:0]  pos;
    logic [2:0]  neg;
    logic        pwr;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'h97, 1'b0, 12'hABC, 12'hABC, 2'd0, 3'd4, 1'b1},
    '{8'hD4, 1'b0, 12'h123, 12'h123, 2'd1, 3'd4, 1'b0},
    '{8'hA3, 1'b0, 12'hFFF, 12'hFFF, 2'd2, 3'd3, 1'b1},
    '{8'hE0, 1'b0, 12'h000, 12'h000, 2'd3, 3'd2, 1'b0},
    '{8'h9F, 1'b0, 12'h7FF, 12'h7FF, 2'd0, 3'd4, 1'b1},
    '{8'h9F, 1'b1, 12'h7FF, 12'h07F, 2'd0, 3'd4, 1'b1},
    '{8'hD9, 1'b1, 12'h800, 12'h080, 2'd1, 3'd0, 1'b1},
    '{8'hA6, 1'b1, 12'h801, 12'h801, 2'd2, 3'd4, 1'b1}
  };

  logic       dinSeq [1:64];
  logic       csSeq  [1:64];
  logic       rDout  [1:64];
  logic       rBusy  [1:64];
  logic       rAcq   [1:64];
  logic       rPwr   [1:64];
  logic       rOe    [1:64];
  logic [1:0] rPos   [1:64];
  logic [2:0] rNeg   [1:64];

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearSeq();
    for (int i = 1; i <= 64; i++) begin
      dinSeq[i] = 1'b0;
      csSeq[i]  = 1'b0;
    end
  endtask

  task automatic putByte(input int at, input logic [7:0] b);
    for (int k = 0; k < 8; k++) dinSeq[at + k] = b[7 - k];
  endtask

  // clock i: inputs set before rising edge i, outputs recorded after the following falling edge
  task automatic runStream(input int len, input int swAt,
                           input logic [11:0] vA, input logic [11:0] vB);
    vinNow = vA;
    for (int i = 1; i <= len; i++) begin
      if (i == swAt) vinNow = vB;
      din = dinSeq[i];
      csN = csSeq[i];
      @(posedge clk);
      @(negedge clk);
      #1;
      rDout[i] = dout;  rBusy[i] = busy;  rAcq[i] = acquire;
      rPwr[i]  = powered; rOe[i] = outEn; rPos[i] = muxPos; rNeg[i] = muxNeg;
    end
    din = 1'b0;
    csN = 1'b0;
  endtask

  function automatic int getCode(input int at, input int nb);
    int c = 0;
    for (int j = 0; j < nb; j++) c = (c << 1) | int'(rDout[at + 8 + j]);
    return c;
  endfunction

  function automatic int busyMap(input int len);
    int m = 0;
    for (int i = 1; i <= len; i++) if (rBusy[i]) m = m + i * 100 + 1;
    return m;
  endfunction

  initial begin
    rstN = 1'b0; csN = 1'b1; din = 1'b0; modePin = 1'b0; shdnN = 1'b1; vinNow = '0;
    repeat (3) @(negedge clk);
    #1;
    // R11: reset state
    chk("R11 dout", dout, 0);
    chk("R11 busy", busy, 0);
    chk("R11 acquire", acquire, 0);
    chk("R11 powered", powered, 0);
    chk("R11 dacCode", dacCode, 0);
    chk("R10 outEn with cs high", outEn, 0);
    rstN = 1'b1;
    csN  = 1'b0;

    // table of commands, one frame each
    for (int v = 0; v < NV; v++) begin
      int nb;
      nb = (VECS[v].pin && VECS[v].ctrl[3]) ? 8 : 12;
      modePin = VECS[v].pin;
      clearSeq();
      putByte(1, VECS[v].ctrl);
      runStream(24, 0, VECS[v].vin, VECS[v].vin);
      chk("R2 muxPos", rPos[8], VECS[v].pos);
      chk("R2 muxNeg", rNeg[8], VECS[v].neg);
      chk("R3 acquire window", {rAcq[4], rAcq[5], rAcq[6], rAcq[7], rAcq[8]}, 5'b01110);
      chk("R4 busy position", busyMap(24), 8 * 100 + 1);
      chk("R5 R6 result code", getCode(1, nb), VECS[v].code);
      chk("R5 dout zero after lsb", rDout[9 + nb], 0);
      chk("R8 powered in conversion", rPwr[12], 1);
      chk("R8 powered after conversion", rPwr[8 + nb], VECS[v].pwr);
    end

    // R7 overlap, full resolution: DIN high through the ignore window
    modePin = 1'b0;
    clearSeq();
    putByte(1, 8'h97);
    for (int i = 9; i <= 15; i++) dinSeq[i] = 1'b1;
    putByte(16, 8'hD4);
    runStream(37, 21, 12'h5A5, 12'h3C3);
    chk("R7 first result during overlap", getCode(1, 12), 12'h5A5);
    chk("R7 second start at clock 16", busyMap(37), (8 * 100 + 1) + (23 * 100 + 1));
    chk("R7 second result", getCode(16, 12), 12'h3C3);
    chk("R5 dout zero after second lsb", rDout[36], 0);

    // R7 overlap, reduced resolution: new start at clock 12
    modePin = 1'b1;
    clearSeq();
    putByte(1, 8'h9F);
    for (int i = 9; i <= 11; i++) dinSeq[i] = 1'b1;
    putByte(12, 8'hD9);
    runStream(29, 17, 12'h3FF, 12'hE10);
    chk("R7 R6 first short result", getCode(1, 8), 8'h3F);
    chk("R7 short start at clock 12", busyMap(29), (8 * 100 + 1) + (19 * 100 + 1));
    chk("R7 R6 second short result", getCode(12, 8), 8'hE1);
    chk("R2 overlap mux", rPos[19], 1);

    // R1 leading zeros ignored
    modePin = 1'b0;
    clearSeq();
    putByte(4, 8'hA3);
    runStream(28, 0, 12'h456, 12'h456);
    chk("R1 busy after delayed start", busyMap(28), 11 * 100 + 1);
    chk("R1 result after delayed start", getCode(4, 12), 12'h456);

    // R10 abort mid-command, DIN high while deselected
    clearSeq();
    dinSeq[1] = 1'b1; dinSeq[2] = 1'b1; dinSeq[3] = 1'b0;
    csSeq[4] = 1'b1; dinSeq[4] = 1'b1;
    putByte(5, 8'hD4);
    runStream(28, 0, 12'h9E7, 12'h9E7);
    chk("R10 outEn low while deselected", rOe[4], 0);
    chk("R10 outEn high when selected", rOe[5], 1);
    chk("R10 restart after abort", busyMap(28), 12 * 100 + 1);
    chk("R10 result after abort", getCode(5, 12), 12'h9E7);

    // R10 abort mid-conversion
    clearSeq();
    putByte(1, 8'h97);
    csSeq[12] = 1'b1;
    runStream(24, 0, 12'hFFF, 12'hFFF);
    chk("R10 dout cleared while deselected", rDout[12], 0);
    chk("R10 no bits after abort", getCode(1, 12), 12'hE00);

    // R9 shutdown overrides always-on
    clearSeq();
    shdnN = 1'b0;
    putByte(1, 8'h97);
    runStream(22, 0, 12'h321, 12'h321);
    chk("R9 powered low in acquisition", rPwr[6], 0);
    chk("R9 powered low in conversion", rPwr[12], 0);
    shdnN = 1'b1;
    #1;
    chk("R9 R8 powered back with keep-on code", powered, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule